// File: doc/BRIEF.md
# Prescaled 8/16-bit Timer-Counter with Overflow Interrupt

This block is a small peripheral that counts either a one-cycle internal tick or edges on an external input. The counting pulses can go through an 8-bit prescaler, whose ratio is a power of two from 2 to 256, or go around it. The counter is 16 bits wide and can also run as an 8-bit counter. A software-visible flag records each overflow, and it drives an interrupt line through an enable bit. While the sleep input is high, counting stops.

Software uses four byte-wide registers: a control byte, the low count byte, a buffered high count byte, and an interrupt register. The high byte works through a buffer register. Reading the low byte captures the live high byte into the buffer. Writing the low byte loads the buffer into the high half at the same time, so a 16-bit value is read or written as one unit. Software cannot see the prescaler count, but every count write clears it. After every count write the counter also waits out two source pulses before it counts again.

Top module: `cfg_tick_timer`

## Requirements
- R1: After reset, the control byte reads 00h, both count bytes read 00h, the interrupt register reads 00h and irq is low.
- R2: Control register (address 0) layout: bit 7 run, bit 6 8-bit mode, bit 5 external source, bit 4 falling-edge select, bit 3 prescaler bypass, bits 2:0 ratio select. It reads back exactly as written and changes only when written.
- R3: With bypass at 0, the counter advances once per 2^(select+1) accepted source pulses. With bypass at 1, it advances on every accepted pulse. Setting or clearing bypass while running keeps the ratio select and the prescaler state.
- R4: In 16-bit mode (bit 6 = 0), the count wraps from FFFFh to 0000h and that step sets the flag.
- R5: In 8-bit mode (bit 6 = 1), the low byte wraps from FFh to 00h and sets the flag, and the high byte does not change.
- R6: A write to the low count byte (address 1) clears the hidden prescaler count and leaves the control byte unchanged.
- R7: After a write to address 1, the first two accepted source pulses do not advance the counter.
- R8: Reading address 1 copies the live high byte into the buffer, and address 2 reads the buffer. A write to address 2 loads only the buffer. A write to address 1 loads {buffer, data} into the count in one cycle.
- R9: Interrupt register (address 3): bit 0 is the overflow flag and bit 1 is the enable. The flag stays set until a write puts 0 in bit 0. If that clear falls in the same cycle as an overflow, the flag ends up set.
- R10: irq is high exactly when both the flag and the enable are set.
- R11: While sleep is high, neither the counter nor the prescaler advances.
- R12: With bit 5 set, the counter counts edges of ext_clk after a two-flop synchronizer: rising edges when bit 4 = 0, falling edges when bit 4 = 1. tick_in is then ignored.
- R13: With run at 0, the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Internal count pulse, one cycle per tick |
| ext_clk | input | 1 | Asynchronous external count input |
| sleep | input | 1 | Freezes counting while high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Overflow interrupt request |

## Verification
A write takes effect at the next clock edge. Read data is valid in the same cycle as the address, and the buffered high byte is readable from the following cycle. An internal tick changes the count at the edge where it is sampled, while an external edge reaches the count three edges after ext_clk changes. So the bench drives every input on the falling clock edge, drops tick_in before any read, waits several cycles after the last external edge, and then reads through the register interface. Each expected count is computed from the start value, the number of pulses less the two held-off ones, and the chosen ratio.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic       run;
    logic       mode8;
    logic       src_ext;
    logic       edge_fall;
    logic       bypass;
    logic [2:0] ratio;
  } tmr_ctrl_t;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CNTL = 2'd1,
    RA_CNTH = 2'd2,
    RA_IRQ  = 2'd3
  } tmr_addr_e;
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  input  logic fall_sel,
  output logic edge_pulse
);
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            cur;
  logic            prev;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cur        = sh_q[STAGES-1];
  assign prev       = sh_q[STAGES];
  assign edge_pulse = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             bypass,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             inc
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] cnt_d;
  logic [PRE_W-1:0] cnt_nx;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i <= int'(ratio_sel));
  end

  assign cnt_nx = PRE_W'(cnt_q + 1'b1);
  assign inc    = adv & (bypass | ((cnt_nx & mask) == '0));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                 cnt_d = '0;
    else if (adv && !bypass) cnt_d = cnt_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SEL_W       = 3,
  parameter int HOLD_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              ext_clk,
  input  logic              sleep,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W  = 2 * DATA_W;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  tmr_ctrl_t           ctrl_q, ctrl_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [DATA_W-1:0]   hbuf_q, hbuf_d;
  logic                flag_q, flag_d;
  logic                ien_q, ien_d;
  logic [HOLD_W-1:0]   hold_q, hold_d;

  logic wr_ctrl, wr_lo, wr_hi, wr_irq, rd_lo;
  logic ext_pulse, src_pulse, active, hold_busy, pre_adv, inc, ovf;

  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_lo   = bus_wr && (bus_addr == RA_CNTL);
  assign wr_hi   = bus_wr && (bus_addr == RA_CNTH);
  assign wr_irq  = bus_wr && (bus_addr == RA_IRQ);
  assign rd_lo   = bus_rd && (bus_addr == RA_CNTL);

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_in     (ext_clk),
    .fall_sel   (ctrl_q.edge_fall),
    .edge_pulse (ext_pulse)
  );

  assign src_pulse = ctrl_q.src_ext ? ext_pulse : tick_in;
  assign active    = ctrl_q.run & ~sleep;
  assign hold_busy = (hold_q != '0);
  assign pre_adv   = active & src_pulse & ~hold_busy & ~wr_lo;

  tmr_prescale #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (wr_lo),
    .adv       (pre_adv),
    .bypass    (ctrl_q.bypass),
    .ratio_sel (ctrl_q.ratio),
    .inc       (inc)
  );

  assign ovf = inc & (ctrl_q.mode8 ? (cnt_q[DATA_W-1:0] == '1) : (cnt_q == '1));

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = tmr_ctrl_t'(bus_wdata);

    cnt_d = cnt_q;
    if (wr_lo) begin
      cnt_d = {hbuf_q, bus_wdata};
    end else if (inc) begin
      if (ctrl_q.mode8) cnt_d = {cnt_q[CNT_W-1:DATA_W], DATA_W'(cnt_q[DATA_W-1:0] + 1'b1)};
      else              cnt_d = CNT_W'(cnt_q + 1'b1);
    end

    hbuf_d = hbuf_q;
    if (wr_hi)      hbuf_d = bus_wdata;
    else if (rd_lo) hbuf_d = cnt_q[CNT_W-1:DATA_W];

    hold_d = hold_q;
    if (wr_lo)                                hold_d = HOLD_W'(HOLD_CYC);
    else if (active && src_pulse && hold_busy) hold_d = HOLD_W'(hold_q - 1'b1);

    flag_d = ovf | (wr_irq ? bus_wdata[0] : flag_q);
    ien_d  = wr_irq ? bus_wdata[1] : ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cnt_q  <= '0;
      hbuf_q <= '0;
      hold_q <= '0;
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cnt_q  <= cnt_d;
      hbuf_q <= hbuf_d;
      hold_q <= hold_d;
      flag_q <= flag_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_CTRL: bus_rdata = ctrl_q;
      RA_CNTL: bus_rdata = cnt_q[DATA_W-1:0];
      RA_CNTH: bus_rdata = hbuf_q;
      default: bus_rdata = {{(DATA_W-2){1'b0}}, ien_q, flag_q};
    endcase
  end

  assign irq = flag_q & ien_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        irq,
  input logic [7:0]  ctrl,
  input logic [15:0] cnt,
  input logic [7:0]  hbuf,
  input logic        flag
);
  logic wr_lo_c, wr_irq_c, wr_ctrl_c;
  assign wr_lo_c   = bus_wr && (bus_addr == 2'd1);
  assign wr_irq_c  = bus_wr && (bus_addr == 2'd3);
  assign wr_ctrl_c = bus_wr && (bus_addr == 2'd0);

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl_c |=> $stable(ctrl)); // R2
  AST_HIGH_FROZEN_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !wr_lo_c) |=> $stable(cnt[15:8])); // R5
  AST_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_c ##1 !wr_lo_c |=> $stable(cnt)); // R7
  AST_ATOMIC_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_c |=> (cnt == $past({hbuf, bus_wdata}))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_irq_c) |=> flag); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_irq_c && !bus_wdata[1]) |=> !irq); // R10
  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_lo_c) |=> $stable(cnt)); // R11
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && !wr_lo_c) |=> $stable(cnt)); // R13
endmodule

bind cfg_tick_timer tmr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep     (sleep),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .ctrl      (ctrl_q),
  .cnt       (cnt_q),
  .hbuf      (hbuf_q),
  .flag      (flag_q)
);

// File: tb/sim_cfg_tick_timer.sv
`timescale 1ns/1ps
module sim_cfg_tick_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic       sleep = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cfg_tick_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .ext_clk(ext_clk), .sleep(sleep),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [15:0] v);
    wr(2'd2, v[15:8]);
    wr(2'd1, v[7:0]);
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic ticks(input int n);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic ext_train(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    ext_clk = 1'b1; repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, b); check("R1 ctrl", int'(b), 0);
    rd16(v);     check("R1 count", int'(v), 0);
    rd(2'd3, b); check("R1 irq reg", int'(b), 0);
    check("R1 irq", int'(irq), 0);

    // R8 buffered high byte
    wr16(16'h1234);
    rd(2'd1, b); check("R8 low", int'(b), 'h34);
    rd(2'd2, b); check("R8 latched high", int'(b), 'h12);
    wr(2'd2, 8'h56);
    rd(2'd2, b); check("R8 buffer write", int'(b), 'h56);
    wr(2'd1, 8'h78);
    rd16(v);     check("R8 atomic commit", int'(v), 'h5678);

    // R3 R4 R5 R2 sweep: mode x bypass x ratio
    for (int m8 = 0; m8 < 2; m8++) begin
      for (int bp = 0; bp < 2; bp++) begin
        for (int sel = 0; sel < 8; sel++) begin
          logic [7:0]  c;
          logic [15:0] st;
          int k, tot, ef;
          logic [15:0] ev;
          c  = 8'(128 + m8 * 64 + bp * 8 + sel);
          st = (m8 == 1) ? 16'h12F0 : 16'hFFA0;
          wr(2'd3, 8'h02);
          wr(2'd0, c);
          wr16(st);
          ticks(300);
          k = (bp == 1) ? 298 : (298 >> (sel + 1));
          if (m8 == 1) begin
            tot = int'(st[7:0]) + k;
            ev  = {st[15:8], 8'(tot)};
            ef  = (tot >= 256) ? 1 : 0;
          end else begin
            tot = int'(st) + k;
            ev  = 16'(tot);
            ef  = (tot >= 65536) ? 1 : 0;
          end
          rd(2'd0, b); check("R2 ctrl readback", int'(b), int'(c));
          rd16(v);
          check((m8 == 1) ? "R5 R3 count 8-bit" : "R4 R3 count 16-bit", int'(v), int'(ev));
          rd(2'd3, b); check((m8 == 1) ? "R5 flag" : "R4 flag", int'(b), 2 + ef);
          check("R10 irq follows flag", int'(irq), ef);
        end
      end
    end

    // R6 count write clears prescaler (ratio 1:4)
    wr(2'd0, 8'h81);
    wr16(16'h0000);
    ticks(5);
    rd16(v);     check("R6 partial prescale", int'(v), 0);
    wr16(16'h0000);
    ticks(5);
    rd16(v);     check("R6 prescaler cleared", int'(v), 0);
    ticks(1);
    rd16(v);     check("R6 fresh ratio", int'(v), 1);
    rd(2'd0, b); check("R6 ctrl unchanged", int'(b), 'h81);

    // R7 holdoff
    wr(2'd0, 8'h88);
    wr16(16'd100);
    ticks(2);
    rd16(v); check("R7 two pulses ignored", int'(v), 100);
    ticks(1);
    rd16(v); check("R7 third pulse counts", int'(v), 101);

    // R3 bypass switched on the fly (ratio 1:8)
    wr(2'd0, 8'h82);
    wr16(16'h0000);
    ticks(10);
    rd16(v);     check("R3 ratio 8", int'(v), 1);
    wr(2'd0, 8'h8A);
    ticks(3);
    rd16(v);     check("R3 bypass on the fly", int'(v), 4);
    rd(2'd0, b); check("R3 ratio kept", int'(b), 'h8A);
    wr(2'd0, 8'h82);
    ticks(7);
    rd16(v);     check("R3 prescaler state kept", int'(v), 4);
    ticks(1);
    rd16(v);     check("R3 ratio resumed", int'(v), 5);

    // R9 clear colliding with overflow
    wr(2'd0, 8'h88);
    wr(2'd3, 8'h02);
    wr16(16'hFFFF);
    tick_in = 1'b1;
    repeat (2) @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h02;
    @(negedge clk);
    bus_wr = 1'b0; tick_in = 1'b0;
    rd(2'd3, b); check("R9 set wins over clear", int'(b), 3);
    check("R10 irq set", int'(irq), 1);
    wr(2'd3, 8'h00);
    rd(2'd3, b); check("R9 software clear", int'(b), 0);

    // R10 masked flag, R9 sticky
    wr16(16'hFFFF);
    ticks(3);
    rd(2'd3, b); check("R10 flag without enable", int'(b), 1);
    check("R10 irq masked", int'(irq), 0);
    ticks(10);
    rd(2'd3, b); check("R9 flag sticky", int'(b), 1);

    // R11 sleep
    wr16(16'd5);
    ticks(2);
    sleep = 1'b1;
    ticks(20);
    sleep = 1'b0;
    rd16(v); check("R11 frozen in sleep", int'(v), 5);
    ticks(3);
    rd16(v); check("R11 resumes", int'(v), 8);

    // R13 run off
    wr(2'd0, 8'h08);
    ticks(10);
    rd16(v); check("R13 stopped", int'(v), 8);

    // R12 external rising edges: 6 rises, 5 falls
    ext_clk = 1'b0; repeat (4) @(negedge clk);
    wr(2'd0, 8'hA8);
    wr16(16'h0000);
    tick_in = 1'b1;
    ext_train(5);
    tick_in = 1'b0;
    rd16(v); check("R12 rising edges", int'(v), 4);
    wr(2'd0, 8'h00);
    ext_clk = 1'b0; repeat (4) @(negedge clk);
    wr(2'd0, 8'hB8);
    wr16(16'h0000);
    ext_train(5);
    rd16(v); check("R12 falling edges", int'(v), 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule